// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Receiver

This block is a receive-only slave on a two-wire serial bus with a clock line and a data line. A bus master uses it to load a small bank of control registers. The block watches both lines through a synchronizer running on a much faster system clock. It recognises start, repeated-start and stop conditions and checks the first byte of each transfer against its own 7-bit address with a write direction bit. It then stores every following data bit straight into the register bank.

There is no shadow copy of the registers. Each bit reaches the parallel output as soon as its clock pulse ends, so a byte that is only partly sent leaves the bits it reached updated and the rest untouched. A stop or a fresh start may cut a transfer short at any bit. The only thing the block ever drives onto the bus is the acknowledge: an active-high enable that pulls the data line low during the ninth clock of each accepted byte.

Top module: `wo_cfg_sink`

## Requirements
- R1: While reset is asserted and right after it, `cfg_out` equals the parameter `CFG_RESET` and `sda_pull` is 0.
- R2: After a start, an address byte sent most significant bit first whose upper seven bits equal `DEV_ADDR` and whose last bit is 0 (write) is acknowledged: `sda_pull` is 1 while SCL is high in the ninth clock.
- R3: An address byte that differs from `DEV_ADDR`, or whose last bit is 1 (read), gets no acknowledge. Every byte after it, up to the next start, gets no acknowledge and leaves `cfg_out` unchanged.
- R4: After a matching address, data byte k (counted from 0) is written to `cfg_out[8k+7:8k]`. The first bit on the wire lands in bit 8k+7. Each such byte is acknowledged in its ninth clock.
- R5: Each data bit appears on `cfg_out` in the SCL low phase right after its own clock pulse, before the next bit is sent. The bits of the byte not yet sent keep their previous values.
- R6: A stop condition (SDA rising while SCL is high) in the middle of a byte ends the transfer. Bits not yet received keep their old values, and the bit clock that forms the stop writes nothing.
- R7: A repeated start (SDA falling while SCL is high) in the middle of a byte ends the transfer without writing. The next matching address makes writes begin again at byte 0.
- R8: Data bytes beyond the NUM_BYTES-th are acknowledged and discarded. `cfg_out` does not change.
- R9: `cfg_out` and `sda_pull` change only while SCL is low.
- R10: `cfg_out` never changes in more than one bit position per system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | High to pull the data line low (open-drain acknowledge) |
| cfg_out | output | NUM_BYTES*8 | Parallel register bank, byte k at bits [8k+7:8k] |

## Verification
The main path is swept over every 8-bit value of the first data byte, paired with a second byte derived arithmetically from it. The register contents are compared after every single bit, which separates per-bit updates from whole-byte commits and detects a reversed bit order. Further patterns are a wrong address and a read-direction address, which test address matching against the direction bit, and a third byte that tests saturation against wrap-around. A stop and a repeated start placed in the middle of a byte show whether the control-condition clock can leak a spurious bit into the registers.

// File: rtl/wo_cfg_pkg.sv
package wo_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_ACK  = 3'd3,
    ST_SKIP = 3'd4
  } bus_state_t;
endpackage

// File: rtl/wo_line_sync.sv
module wo_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_in,
  output logic [WIDTH-1:0] line_now,
  output logic [WIDTH-1:0] line_prev
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  // bus lines idle high, so every stage resets to 1
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else if (g == 0) stage_q[g] <= line_in;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else prev_q <= stage_q[STAGES-1];
  end

  assign line_now  = stage_q[STAGES-1];
  assign line_prev = prev_q;
endmodule

// File: rtl/wo_bus_ctrl.sv
module wo_bus_ctrl
  import wo_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h2C,
  parameter int         NUM_BYTES = 4,
  localparam int        IDX_W     = $clog2(NUM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_now,
  input  logic             scl_prev,
  input  logic             sda_now,
  input  logic             sda_prev,
  output logic             pull_o,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [2:0]       wr_bit,
  output logic             wr_val,
  output logic             idle_o
);
  localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(NUM_BYTES);

  bus_state_t       state_q, state_n;
  logic [2:0]       cnt_q, cnt_n;
  logic [6:0]       shr_q, shr_n;
  logic             bit_q, bit_n;
  logic             bok_q, bok_n;
  logic             pull_q, pull_n;
  logic [IDX_W-1:0] idx_q, idx_n;

  logic start_ev, stop_ev, rise_ev, fall_ev, in_range;

  assign start_ev = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_ev  = scl_now & scl_prev & ~sda_prev & sda_now;
  assign rise_ev  = scl_now & ~scl_prev;
  assign fall_ev  = ~scl_now & scl_prev;
  assign in_range = (idx_q != IDX_LIMIT);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    shr_n   = shr_q;
    bit_n   = bit_q;
    bok_n   = bok_q;
    pull_n  = pull_q;
    idx_n   = idx_q;
    wr_en   = 1'b0;
    if (start_ev) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      bok_n   = 1'b0;
      pull_n  = 1'b0;
      idx_n   = '0;
    end else if (stop_ev) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      bok_n   = 1'b0;
      pull_n  = 1'b0;
    end else if (rise_ev) begin
      bok_n = 1'b1;
      bit_n = sda_now;
    end else if (fall_ev && bok_q) begin
      bok_n = 1'b0;
      unique case (state_q)
        ST_ADDR: begin
          shr_n = {shr_q[5:0], bit_q};
          cnt_n = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            if ({shr_q, bit_q} == {DEV_ADDR, 1'b0}) begin
              pull_n  = 1'b1;
              state_n = ST_ACK;
            end else begin
              state_n = ST_SKIP;
            end
          end
        end
        ST_DATA: begin
          wr_en = in_range;
          cnt_n = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            pull_n  = 1'b1;
            state_n = ST_ACK;
            if (in_range) idx_n = idx_q + 1'b1;
          end
        end
        ST_ACK: begin
          pull_n  = 1'b0;
          state_n = ST_DATA;
          cnt_n   = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shr_q   <= '0;
      bit_q   <= 1'b0;
      bok_q   <= 1'b0;
      pull_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      shr_q   <= shr_n;
      bit_q   <= bit_n;
      bok_q   <= bok_n;
      pull_q  <= pull_n;
      idx_q   <= idx_n;
    end
  end

  assign pull_o = pull_q;
  assign wr_idx = idx_q;
  assign wr_bit = ~cnt_q;
  assign wr_val = bit_q;
  assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/wo_cfg_regs.sv
module wo_cfg_regs #(
  parameter int                       NUM_BYTES = 4,
  parameter logic [NUM_BYTES*8-1:0]   CFG_RESET = {NUM_BYTES{8'hA5}},
  localparam int                      IDX_W     = $clog2(NUM_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [2:0]             wr_bit,
  input  logic                   wr_val,
  output logic [NUM_BYTES*8-1:0] cfg_o
);
  genvar k;
  generate
    for (k = 0; k < NUM_BYTES; k++) begin : g_byte
      logic [7:0] byte_q;
      logic       sel;
      assign sel = wr_en && (wr_idx == IDX_W'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byte_q <= CFG_RESET[8*k +: 8];
        else if (sel) byte_q[wr_bit] <= wr_val;
      end
      assign cfg_o[8*k +: 8] = byte_q;
    end
  endgenerate
endmodule

// File: rtl/wo_cfg_sink.sv
module wo_cfg_sink #(
  parameter logic [6:0]               DEV_ADDR  = 7'h2C,
  parameter int                       NUM_BYTES = 4,
  parameter logic [NUM_BYTES*8-1:0]   CFG_RESET = {NUM_BYTES{8'hA5}}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_in,
  input  logic                   sda_in,
  output logic                   sda_pull,
  output logic [NUM_BYTES*8-1:0] cfg_out
);
  localparam int IDX_W = $clog2(NUM_BYTES + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_q_n;
  logic [1:0]       ln_now, ln_prev;
  logic             scl_s;
  logic             wr_en, wr_val, bus_idle;
  logic [IDX_W-1:0] wr_idx;
  logic [2:0]       wr_bit;

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  wo_line_sync #(.WIDTH(2), .STAGES(2)) i_sync (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .line_in  ({scl_in, sda_in}),
    .line_now (ln_now),
    .line_prev(ln_prev)
  );
  assign scl_s = ln_now[1];

  wo_bus_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_BYTES(NUM_BYTES)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .scl_now (ln_now[1]),
    .scl_prev(ln_prev[1]),
    .sda_now (ln_now[0]),
    .sda_prev(ln_prev[0]),
    .pull_o  (sda_pull),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_bit  (wr_bit),
    .wr_val  (wr_val),
    .idle_o  (bus_idle)
  );

  wo_cfg_regs #(.NUM_BYTES(NUM_BYTES), .CFG_RESET(CFG_RESET)) i_regs (
    .clk   (clk),
    .rst_n (rst_q_n),
    .wr_en (wr_en),
    .wr_idx(wr_idx),
    .wr_bit(wr_bit),
    .wr_val(wr_val),
    .cfg_o (cfg_out)
  );
endmodule

// File: rtl/wo_cfg_sink_chk.sv
module wo_cfg_sink_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_s,
  input logic         idle,
  input logic         sda_pull,
  input logic [W-1:0] cfg_out
);
  // R10
  one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_out) |-> $countones(cfg_out ^ $past(cfg_out)) == 1);

  // R9
  cfg_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_out) |-> !scl_s);

  // R9
  pull_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  // R2
  pull_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_pull);
endmodule

bind wo_cfg_sink wo_cfg_sink_chk #(.W(NUM_BYTES*8)) i_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .scl_s   (scl_s),
  .idle    (bus_idle),
  .sda_pull(sda_pull),
  .cfg_out (cfg_out)
);

// File: tb/test_wo_cfg_sink.sv
module test_wo_cfg_sink;
  localparam int         CLK_PERIOD = 10;
  localparam int         NB         = 2;
  localparam int         H          = 6;
  localparam logic [6:0] ADDR       = 7'h2C;
  localparam logic [15:0] RSTV      = 16'hA55A;

  logic clk, rst_n, scl_m, sda_m, sda_pull;
  logic [NB*8-1:0] cfg_out;
  logic [7:0] expb [NB];
  int total, bad, r9_bad, r10_bad;
  logic [NB*8-1:0] prev_cfg;

  wire sda_line = sda_m & ~sda_pull;

  wo_cfg_sink #(.DEV_ADDR(ADDR), .NUM_BYTES(NB), .CFG_RESET(RSTV)) i_wo_cfg_sink (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .cfg_out(cfg_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_cfg();
    return {expb[1], expb[0]};
  endfunction

  // R9 / R10 monitor on the output between system clock edges
  always @(negedge clk) begin
    if (rst_n && cfg_out !== prev_cfg) begin
      if (scl_m) r9_bad++;
      if ($countones(cfg_out ^ prev_cfg) != 1) r10_bad++;
    end
    prev_cfg = cfg_out;
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(H);
    scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; tick(H);
    scl_m = 1'b1; tick(H);
    scl_m = 1'b0;
  endtask

  // slot < 0: no per-bit check
  task automatic send_byte(input logic [7:0] b, input int slot, output bit ack);
    for (int i = 0; i < 8; i++) begin
      send_bit(b[7-i]);
      if (slot >= 0) begin
        logic [7:0] m;
        logic [7:0] e;
        m = 8'hFF << (7 - i);
        e = (b & m) | (expb[slot] & ~m);
        tick(H-1);
        // R5 bit lands before the next one is sent
        chk(cfg_out[slot*8 +: 8] == e, "R5", {24'd0, cfg_out[slot*8 +: 8]}, {24'd0, e});
      end
    end
    sda_m = 1'b1; tick(H);
    scl_m = 1'b1; tick(H/2);
    ack = sda_pull;
    tick(H - H/2);
    scl_m = 1'b0;
    if (slot >= 0) expb[slot] = b;
  endtask

  initial begin
    bit ack;
    total = 0; bad = 0; r9_bad = 0; r10_bad = 0;
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    prev_cfg = RSTV;
    tick(5);
    // R1 reset state
    chk(cfg_out == RSTV, "R1", {16'd0, cfg_out}, {16'd0, RSTV});
    chk(sda_pull == 1'b0, "R1", {31'd0, sda_pull}, 32'd0);
    rst_n = 1'b1; tick(4);
    chk(cfg_out == RSTV, "R1", {16'd0, cfg_out}, {16'd0, RSTV});
    expb[0] = RSTV[7:0]; expb[1] = RSTV[15:8];

    // R2 R4 R5 sweep over every first-byte value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b0, b1;
      b0 = 8'(v);
      b1 = 8'((v * 37 + 11) & 255);
      bus_start();
      send_byte({ADDR, 1'b0}, -1, ack);
      chk(ack == 1'b1, "R2", {31'd0, ack}, 32'd1);
      send_byte(b0, 0, ack);
      chk(ack == 1'b1, "R4", {31'd0, ack}, 32'd1);
      send_byte(b1, -1, ack);
      expb[1] = b1;
      chk(ack == 1'b1, "R4", {31'd0, ack}, 32'd1);
      bus_stop();
      chk(cfg_out == exp_cfg(), "R4", {16'd0, cfg_out}, {16'd0, exp_cfg()});
    end

    // R8 extra byte acknowledged and dropped
    bus_start();
    send_byte({ADDR, 1'b0}, -1, ack);
    send_byte(8'h11, -1, ack); expb[0] = 8'h11;
    send_byte(8'h22, -1, ack); expb[1] = 8'h22;
    send_byte(8'hEE, -1, ack);
    chk(ack == 1'b1, "R8", {31'd0, ack}, 32'd1);
    tick(4);
    chk(cfg_out == exp_cfg(), "R8", {16'd0, cfg_out}, {16'd0, exp_cfg()});
    bus_stop();

    // R3 wrong address
    bus_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, -1, ack);
    chk(ack == 1'b0, "R3", {31'd0, ack}, 32'd0);
    send_byte(8'hC3, -1, ack);
    chk(ack == 1'b0, "R3", {31'd0, ack}, 32'd0);
    chk(cfg_out == exp_cfg(), "R3", {16'd0, cfg_out}, {16'd0, exp_cfg()});
    bus_stop();
    // R3 read direction
    bus_start();
    send_byte({ADDR, 1'b1}, -1, ack);
    chk(ack == 1'b0, "R3", {31'd0, ack}, 32'd0);
    send_byte(8'h3C, -1, ack);
    chk(ack == 1'b0, "R3", {31'd0, ack}, 32'd0);
    chk(cfg_out == exp_cfg(), "R3", {16'd0, cfg_out}, {16'd0, exp_cfg()});
    bus_stop();

    // R6 stop after three bits of byte 0
    bus_start();
    send_byte({ADDR, 1'b0}, -1, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    tick(4);
    expb[0] = {3'b011, expb[0][4:0]};
    chk(cfg_out == exp_cfg(), "R6", {16'd0, cfg_out}, {16'd0, exp_cfg()});

    // R7 repeated start two bits into byte 1
    bus_start();
    send_byte({ADDR, 1'b0}, -1, ack);
    send_byte(8'h96, 0, ack);
    send_bit(1'b0); send_bit(1'b0);
    expb[1] = {2'b00, expb[1][5:0]};
    bus_start();
    tick(4);
    chk(cfg_out == exp_cfg(), "R7", {16'd0, cfg_out}, {16'd0, exp_cfg()});
    send_byte({ADDR, 1'b0}, -1, ack);
    chk(ack == 1'b1, "R7", {31'd0, ack}, 32'd1);
    send_byte(8'h5E, 0, ack);
    bus_stop();
    chk(cfg_out == exp_cfg(), "R7", {16'd0, cfg_out}, {16'd0, exp_cfg()});

    chk(r9_bad == 0, "R9", r9_bad, 0);
    chk(r10_bad == 0, "R10", r10_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule